// File: doc/BRIEF.md
# Fuse Array Burst Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse array. A host gives a start pulse with a first address and a byte count. The block then drives the array's select, load, program-enable and strobe pins and its 8-bit address bus in a fixed order, with a settle gap of a set number of microseconds between each step. The array stays selected for the whole burst. The address steps up by one after each byte and wraps modulo 256.

Every byte the block captures comes out on a valid/ready stream that carries the byte and its fuse address. The stream accepts back-pressure. Once the strobe-high settle time has passed, the block raises `rd_valid_o` and holds it. It keeps `rd_data_o`, `rd_addr_o` and the strobe pin steady until the sink raises `rd_ready_i`. A beat transfers on a cycle where valid and ready are both high, and the strobe drops on the next cycle. When `rd_ready_i` is held high, each beat lasts exactly one cycle. The microsecond gaps are clock-cycle counts. They are derived from the `CLK_HZ` parameter and rounded up, with a minimum of one cycle.

Top module: `efuse_burst_rd`

## Requirements
- R1: After reset the block is idle: `busy_o` and `rd_valid_o` are 0, `fuse_csb_o` (active-low select) is 1, and `fuse_load_o`, `fuse_pgenb_o` (active-low program enable) and `fuse_strobe_o` are 0.
- R2: The first busy cycle of an accepted burst keeps the array deselected, with select high and the other three controls low. From the next cycle on, select is low. Whenever select is low, load and program-enable are both high.
- R3: The first strobe rises 2*T2+1 cycles after select falls. The address bus reads 0 for exactly one cycle, then shows the byte's address for the T2 cycles before the strobe rises and at the rise itself.
- R4: After the strobe has been high for T2 cycles, `rd_valid_o` rises while the strobe is still high. `rd_data_o` carries the array output sampled during strobe-high for address `rd_addr_o`. The strobe falls one cycle after the beat is accepted.
- R5: While `rd_valid_o` is high and `rd_ready_i` is low, on the next cycle valid stays high, data and address do not change, and the strobe stays high.
- R6: Between bytes, the next strobe rises 2*T2+1 cycles after the previous strobe fell.
- R7: A burst delivers exactly the requested number of beats. Beat addresses run from the start address upward by one and wrap from 255 to 0.
- R8: Select rises 2*T2 cycles after the last strobe falls, and `busy_o` falls T1 cycles after that.
- R9: A start pulse with a byte count of 0 does not raise busy, does not move any array pin and produces no beat.
- R10: A start pulse that arrives while `busy_o` is high is dropped. It changes neither the running burst nor anything after it.
- R11: Tn = max(1, ceil(n * CLK_HZ / 1_000_000)) cycles for a wait of n microseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle burst request |
| start_addr_i | input | 8 | First fuse address |
| byte_cnt_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | Burst in progress |
| fuse_csb_o | output | 1 | Array select, active low |
| fuse_load_o | output | 1 | Array load control |
| fuse_pgenb_o | output | 1 | Program enable, active low (held high to read) |
| fuse_strobe_o | output | 1 | Read strobe |
| fuse_addr_o | output | 8 | Array address bus |
| fuse_dout_i | input | 8 | Array read data |
| rd_valid_o | output | 1 | Captured byte available |
| rd_ready_i | input | 1 | Sink accepts the byte |
| rd_data_o | output | 8 | Captured byte |
| rd_addr_o | output | 8 | Fuse address of the captured byte |

## Verification
The bench builds the block with `CLK_HZ` = 1_500_000. This rounds a 1 µs wait up to 2 cycles and a 2 µs wait to 3 cycles, so the rounding rule is exercised and every phase stays short. With gaps this short, the bench can read one byte from every one of the 256 start addresses and run a full 256-byte burst that crosses the wrap. It also runs short wrapping bursts under random ready stalls. Each phase length is measured at the pins and compared against the arithmetic T1/T2 values.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DESEL, ST_ENTER, ST_ACLR, ST_ASET,
    ST_STRB, ST_CAPT, ST_SLOW, ST_TAIL, ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic csb;
    logic load;
    logic pgenb;
    logic strobe;
  } fuse_pins_t;

  // cycles for a wait of `us` microseconds, rounded up, never below one
  function automatic int us_cycles(longint hz, int us);
    longint c;
    c = (hz * longint'(us) + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic fuse_pins_t pins_for(seq_st_e s);
    fuse_pins_t p;
    unique case (s)
      ST_IDLE, ST_DESEL: p = '{csb: 1'b1, load: 1'b0, pgenb: 1'b0, strobe: 1'b0};
      ST_STRB, ST_CAPT:  p = '{csb: 1'b0, load: 1'b1, pgenb: 1'b1, strobe: 1'b1};
      ST_FIN:            p = '{csb: 1'b1, load: 1'b1, pgenb: 1'b1, strobe: 1'b0};
      default:           p = '{csb: 1'b0, load: 1'b1, pgenb: 1'b1, strobe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/efuse_us_timer.sv
module efuse_us_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/efuse_burst_ctr.sv
module efuse_burst_ctr #(
  parameter int AW   = 8,
  parameter int CNTW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            step_i,
  output logic [AW-1:0]   addr_o,
  output logic            none_left_o
);
  logic [AW-1:0]   addr_q;
  logic [CNTW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      left_q <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      left_q <= left_q - CNTW'(1);
    end
  end

  assign addr_o      = addr_q;
  assign none_left_o = (left_q == '0);
endmodule

// File: rtl/efuse_seq_fsm.sv
module efuse_seq_fsm
  import efuse_rd_pkg::*;
#(
  parameter int TW = 4,
  parameter int T1 = 1,
  parameter int T2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          tmr_done_i,
  input  logic          none_left_i,
  input  logic          ready_i,
  output seq_st_e       st_q_o,
  output seq_st_e       st_d_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_len_o,
  output logic          step_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (go_i)       st_d = ST_DESEL;
      ST_DESEL:                 st_d = ST_ENTER;
      ST_ENTER: if (tmr_done_i) st_d = ST_ACLR;
      ST_ACLR:                  st_d = ST_ASET;
      ST_ASET:  if (tmr_done_i) st_d = ST_STRB;
      ST_STRB:  if (tmr_done_i) st_d = ST_CAPT;
      ST_CAPT:  if (ready_i)    st_d = ST_SLOW;
      ST_SLOW:  if (tmr_done_i) st_d = none_left_i ? ST_TAIL : ST_ACLR;
      ST_TAIL:  if (tmr_done_i) st_d = ST_FIN;
      ST_FIN:   if (tmr_done_i) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    tmr_load_o = 1'b0;
    if (st_d != st_q) begin
      unique case (st_d)
        ST_ENTER, ST_ASET, ST_STRB, ST_SLOW, ST_TAIL, ST_FIN: tmr_load_o = 1'b1;
        default: tmr_load_o = 1'b0;
      endcase
    end
  end

  assign tmr_len_o = (st_d == ST_FIN) ? TW'(T1) : TW'(T2);
  assign step_o    = (st_q == ST_CAPT) && ready_i;
  assign st_q_o    = st_q;
  assign st_d_o    = st_d;
endmodule

// File: rtl/efuse_burst_rd.sv
module efuse_burst_rd
  import efuse_rd_pkg::*;
#(
  parameter longint CLK_HZ = 125_000_000,
  parameter int     CNT_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       start_addr_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  output logic             busy_o,
  output logic             fuse_csb_o,
  output logic             fuse_load_o,
  output logic             fuse_pgenb_o,
  output logic             fuse_strobe_o,
  output logic [7:0]       fuse_addr_o,
  input  logic [7:0]       fuse_dout_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       rd_addr_o
);
  localparam int T1 = us_cycles(CLK_HZ, 1);
  localparam int T2 = us_cycles(CLK_HZ, 2);
  localparam int TMAX = (T2 > T1) ? T2 : T1;
  localparam int TW = $clog2(TMAX + 1);

  seq_st_e       st_q, st_d;
  logic          go, tmr_load, tmr_done, none_left, step;
  logic [TW-1:0] tmr_len;
  logic [7:0]    cur_addr;
  fuse_pins_t    pins_q;
  logic [7:0]    addr_q, data_q;

  assign go = start_i && (st_q == ST_IDLE) && (byte_cnt_i != '0);

  efuse_seq_fsm #(.TW(TW), .T1(T1), .T2(T2)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(go), .tmr_done_i(tmr_done),
    .none_left_i(none_left), .ready_i(rd_ready_i),
    .st_q_o(st_q), .st_d_o(st_d), .tmr_load_o(tmr_load),
    .tmr_len_o(tmr_len), .step_o(step)
  );

  efuse_us_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .len_i(tmr_len), .done_o(tmr_done)
  );

  efuse_burst_ctr #(.AW(8), .CNTW(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load_i(go), .addr_i(start_addr_i),
    .cnt_i(byte_cnt_i), .step_i(step), .addr_o(cur_addr), .none_left_o(none_left)
  );

  // pins registered from next state: glitch-free and aligned with st_q
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= pins_for(ST_IDLE);
    else        pins_q <= pins_for(st_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      unique case (st_d)
        ST_IDLE, ST_DESEL, ST_ENTER, ST_ACLR: addr_q <= '0;
        ST_ASET: if (st_q != ST_ASET) addr_q <= cur_addr;
        default: addr_q <= addr_q;
      endcase
    end
  end

  // sample array output on the last strobe-high settle cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    data_q <= '0;
    else if (st_q == ST_STRB && st_d == ST_CAPT)   data_q <= fuse_dout_i;
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign fuse_csb_o    = pins_q.csb;
  assign fuse_load_o   = pins_q.load;
  assign fuse_pgenb_o  = pins_q.pgenb;
  assign fuse_strobe_o = pins_q.strobe;
  assign fuse_addr_o   = addr_q;
  assign rd_valid_o    = (st_q == ST_CAPT);
  assign rd_data_o     = data_q;
  assign rd_addr_o     = addr_q;
endmodule

// File: rtl/efuse_burst_rd_chk.sv
module efuse_burst_rd_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CNT_W-1:0] byte_cnt_i,
  input logic             busy_o,
  input logic             fuse_csb_o,
  input logic             fuse_load_o,
  input logic             fuse_pgenb_o,
  input logic             fuse_strobe_o,
  input logic [7:0]       fuse_addr_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic [7:0]       rd_data_o,
  input logic [7:0]       rd_addr_o
);
  // R2
  read_mode_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fuse_csb_o |-> (fuse_load_o && fuse_pgenb_o));

  // R4
  valid_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (fuse_strobe_o && !fuse_csb_o));

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=>
      (rd_valid_o && fuse_strobe_o && $stable(rd_data_o) && $stable(rd_addr_o)));

  // R3
  addr_steady_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_strobe_o) |-> $stable(fuse_addr_o));

  // R4
  strobe_drop_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_strobe_o) |-> $past(rd_valid_o && rd_ready_i));

  // R9
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && byte_cnt_i == '0) |=> (!busy_o && fuse_csb_o));

  // R10
  busy_start_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !fuse_csb_o) |=> busy_o);
endmodule

bind efuse_burst_rd efuse_burst_rd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
  .busy_o(busy_o), .fuse_csb_o(fuse_csb_o), .fuse_load_o(fuse_load_o),
  .fuse_pgenb_o(fuse_pgenb_o), .fuse_strobe_o(fuse_strobe_o),
  .fuse_addr_o(fuse_addr_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_data_o(rd_data_o), .rd_addr_o(rd_addr_o)
);

// File: tb/sim_efuse_burst_rd.sv
module sim_efuse_burst_rd;
  localparam longint HZ = 1_500_000;
  localparam int CW = 9;
  localparam int W1 = ((HZ + 999_999) / 1_000_000 < 1) ? 1 : int'((HZ + 999_999) / 1_000_000);
  localparam int W2 = ((2 * HZ + 999_999) / 1_000_000 < 1) ? 1 : int'((2 * HZ + 999_999) / 1_000_000);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rdy = 1'b1, stall = 1'b0;
  logic [7:0] saddr = '0;
  logic [CW-1:0] scnt = '0;
  logic busy, csb, load, pgenb, strobe, valid;
  logic [7:0] faddr, fdout, rdata, raddr;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fmod(logic [7:0] a);
    return (a * 8'd37 + 8'd11) ^ {a[3:0], a[7:4]};
  endfunction

  assign fdout = strobe ? fmod(faddr) : 8'h00;

  efuse_burst_rd #(.CLK_HZ(HZ), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(saddr),
    .byte_cnt_i(scnt), .busy_o(busy), .fuse_csb_o(csb), .fuse_load_o(load),
    .fuse_pgenb_o(pgenb), .fuse_strobe_o(strobe), .fuse_addr_o(faddr),
    .fuse_dout_i(fdout), .rd_valid_o(valid), .rd_ready_i(rdy),
    .rd_data_o(rdata), .rd_addr_o(raddr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy = stall ? lfsr[0] : 1'b1;
  end

  // pin and stream monitor
  logic [7:0] exp_addr = '0;
  int beats = 0;
  logic mon_en = 1'b0;
  int tcyc = 0, t_busy = 0, t_csbf = 0, t_sr = 0, t_sf = 0, t_hs = 0, t_csbr = 0;
  bit first = 1'b0, hold = 1'b0;
  logic [7:0] hist [0:7];
  logic [7:0] sv_d, sv_a;
  logic p_busy = 1'b0, p_csb = 1'b1, p_str = 1'b0, p_val = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      tcyc++;
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = faddr;
      if (busy && !p_busy) begin
        t_busy = tcyc; first = 1'b1;
        chk(csb && !load && !pgenb && !strobe, "R2 deselect first", {csb, load, pgenb}, 3'b100);
      end
      if (!csb && p_csb) chk(tcyc - t_busy == 1, "R2 select timing", tcyc - t_busy, 1);
      if (!csb) chk(load && pgenb, "R2 read mode pins", {load, pgenb}, 2'b11);
      if (strobe && !p_str) begin
        if (first) chk(tcyc - t_csbf == 2*W2+1, "R3 entry settle", tcyc - t_csbf, 2*W2+1);
        else       chk(tcyc - t_sf == 2*W2+1, "R6 byte gap", tcyc - t_sf, 2*W2+1);
        chk(hist[W2+1] == 8'h00, "R3 address cleared", hist[W2+1], 0);
        for (int k = 0; k <= W2; k++)
          chk(hist[k] == exp_addr, "R3 address setup", hist[k], exp_addr);
        first = 1'b0; t_sr = tcyc;
      end
      if (!csb && p_csb) t_csbf = tcyc;
      if (hold) chk(valid && strobe && rdata == sv_d && raddr == sv_a,
                    "R5 stall hold", {valid, strobe, rdata}, {2'b11, sv_d});
      if (valid && !p_val) begin
        chk(tcyc - t_sr == W2, "R4 R11 strobe settle", tcyc - t_sr, W2);
        chk(strobe, "R4 strobe high at valid", strobe, 1);
      end
      hold = valid && !rdy;
      sv_d = rdata; sv_a = raddr;
      if (valid && rdy) begin
        chk(raddr == exp_addr, "R7 beat address", raddr, exp_addr);
        chk(rdata == fmod(exp_addr), "R4 beat data", rdata, fmod(exp_addr));
        exp_addr = exp_addr + 8'd1; beats++; t_hs = tcyc;
      end
      if (!strobe && p_str) begin
        chk(tcyc - t_hs == 1, "R4 strobe drop", tcyc - t_hs, 1);
        t_sf = tcyc;
      end
      if (csb && !p_csb) begin
        chk(tcyc - t_sf == 2*W2, "R8 tail gap", tcyc - t_sf, 2*W2);
        t_csbr = tcyc;
      end
      if (!busy && p_busy) begin
        chk(tcyc - t_csbr == W1, "R8 final gap", tcyc - t_csbr, W1);
        chk(W1 == 2 && W2 == 3, "R11 rounding", W2, 3);
      end
      p_busy = busy; p_csb = csb; p_str = strobe; p_val = valid;
    end
  end

  task automatic burst(input logic [7:0] a, input int n, input bit stl);
    stall = stl;
    @(posedge clk); #1;
    start = 1'b1; saddr = a; scnt = CW'(n);
    exp_addr = a; beats = 0;
    @(posedge clk); #1;
    start = 1'b0;
    do @(negedge clk); while (busy);
    #1;
    chk(beats == n, "R7 beat count", beats, n);
    stall = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) hist[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !valid && csb && !load && !pgenb && !strobe, "R1 reset pins",
        {busy, valid, csb, load, pgenb, strobe}, 6'b001000);
    mon_en = 1'b1;

    // R7 every start address, single byte
    for (int a = 0; a < 256; a++) burst(8'(a), 1, 1'b0);
    // R5 R7 short wrapping bursts with stalls
    for (int n = 1; n <= 6; n++) burst(8'hFB, n, 1'b1);
    // R7 full-range burst crossing the wrap
    burst(8'h80, 256, 1'b0);

    // R9 zero count
    @(posedge clk); #1;
    start = 1'b1; saddr = 8'h42; scnt = '0;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!busy && csb && !strobe && !load && !valid && faddr == 8'h00,
          "R9 zero count quiet", {busy, csb, strobe, load, valid}, 5'b01000);
    end

    // R10 start while busy
    stall = 1'b0;
    @(posedge clk); #1;
    start = 1'b1; saddr = 8'h10; scnt = CW'(3);
    exp_addr = 8'h10; beats = 0;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (9) @(posedge clk);
    #1 start = 1'b1; saddr = 8'hC0; scnt = CW'(5);
    @(posedge clk); #1;
    start = 1'b0;
    repeat (14) @(posedge clk);
    #1 start = 1'b1; saddr = 8'h33; scnt = CW'(2);
    @(posedge clk); #1;
    start = 1'b0;
    do @(negedge clk); while (busy);
    chk(beats == 3, "R10 burst length kept", beats, 3);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!busy && csb, "R10 no deferred start", busy, 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule